// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Checker

This block sits between a two-wide decode stage and the execution units of a processor core. In every cycle it is offered two decoded instructions, slot 0 (the older) and slot 1 (the younger). Each carries a valid bit and an operation class. The block decides which of them may issue in that cycle without asking for an execution resource that is already occupied. It keeps one down-counter per execution unit that holds the number of further cycles the unit stays occupied. A separate lock counter holds off all issue while a block-move instruction owns both issue slots.

There are thirteen tracked units:
- an immediate-move unit;
- two integer ALUs;
- a branch unit;
- memory write and read ports;
- an extended-arithmetic access port and the extended-arithmetic engine behind it;
- an FP compare unit;
- four FP units.

Most classes hold their unit for the issue cycle only. The engine operations and the FP divide hold their unit for a class-specific number of cycles. A block move freezes issue for sixteen cycles.

The decision is registered. The grant bits and the code of the unit each granted instruction was steered to appear one clock after the candidates were sampled. Operand dependencies, instruction buffering and the execution datapaths are left to other blocks. An instruction that is not granted is expected to be presented again by the front end.

Top module: `hzc_dual_issue_check`

## Requirements
- R1: A synchronous active-high reset clears every unit counter and the block-move lock. In the cycle after any clock edge with reset high, both grant bits are 0 and both unit outputs are 15.
- R2: The grant for slot N appears on grant_o[N] one clock after its candidate was sampled. The steered-unit code appears on the unit output of that slot in the same cycle. The unit codes are: 0 immediate-move, 1 ALU 1, 2 ALU 2, 3 branch, 4 memory write, 5 memory read, 6 extended-arithmetic port, 7 extended-arithmetic engine, 8 FP compare, 9 to 12 FP units 1 to 4. Code 15 means no unit: the slot was not granted, or its class uses no unit.
- R3: Slot 0 has priority. Slot 1 can be granted only in a cycle where slot 0 is granted, and only when its unit is free and was not taken by slot 0 in that cycle.
- R4: An ALU-class instruction uses ALU 1 when ALU 1 is free and not taken by slot 0 in that cycle, and otherwise uses ALU 2. Two ALU instructions in one cycle therefore go to ALU 1 (slot 0) and ALU 2 (slot 1).
- R5: The following classes occupy one unit for their issue cycle only, so that unit can be granted again in the next cycle:
  - immediate move → code 0
  - branch → 3
  - memory write → 4
  - memory read → 5
  - write into the extended-arithmetic module → 6
  - FP register read → 6
  - FP compare → 8
  - FP move or conversion → 9
  - FP arithmetic → 10
  - integer-to-FP write → 12
- R6: Read from the extended-arithmetic module, double-width shift, multiply, divide and double-width divide each take the extended-arithmetic port for the issue cycle. They take the engine (reported as code 7) for 1, 2, 3, 34 and 66 cycles in total, respectively. An engine request is refused until that many cycles after the previous engine grant.
- R7: An FP divide or square root occupies FP unit 3 (code 11) for 15 cycles in total.
- R8: A block move is granted only from slot 0 and reports unit 15. No instruction in either slot is granted in the following 15 cycles. A block move in slot 1 is never granted.
- R9: The class encodings are:

  | Code | Class |
  |---|---|
  | 0 | no-operation |
  | 1 | immediate move |
  | 2 | ALU |
  | 3 | branch |
  | 4 | memory write |
  | 5 | memory read |
  | 6 | write into the extended-arithmetic module |
  | 7 | read from the extended-arithmetic module |
  | 8 | double-width shift |
  | 9 | multiply |
  | 10 | divide |
  | 11 | double-width divide |
  | 12 | FP register read |
  | 13 | FP compare |
  | 14 | FP move or conversion |
  | 15 | FP arithmetic |
  | 16 | FP divide or square root |
  | 17 | integer-to-FP write |
  | 18 | block move |

  A no-operation uses no unit. It is granted whenever its slot may issue, and reports unit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 2 | Candidate present, bit N for slot N |
| cls0_i | input | 5 | Operation class of the slot 0 candidate |
| cls1_i | input | 5 | Operation class of the slot 1 candidate |
| grant_o | output | 2 | Registered issue grant, bit N for slot N |
| unit0_o | output | 4 | Registered unit code for slot 0 |
| unit1_o | output | 4 | Registered unit code for slot 1 |

## Verification
Two functions can collide in one cycle: a held-off resource becoming free, and a second slot competing for a resource shared with it. One collision is an engine counter running out in the very cycle that slot 0 asks for the engine while slot 1 asks for the port. Another is the block-move lock ending while a long divide still holds the engine. The bench provokes both by presenting the same request pair on every cycle of a long hold, so the boundary cycle is always covered. A behavioural reference model counts the occupied cycles from the requirement numbers and judges each registered grant and unit code. A long random run with occasional resets mixes every class in both slots.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  localparam int CLS_W     = 5;
  localparam int UNIT_W    = 4;
  localparam int NUM_UNITS = 13;

  // R9 class encodings
  typedef enum logic [CLS_W-1:0] {
    CL_NOP    = 5'd0,
    CL_IMM    = 5'd1,
    CL_ALU    = 5'd2,
    CL_BR     = 5'd3,
    CL_MWR    = 5'd4,
    CL_MRD    = 5'd5,
    CL_XWR    = 5'd6,
    CL_XRD    = 5'd7,
    CL_SHD    = 5'd8,
    CL_MUL    = 5'd9,
    CL_DIV    = 5'd10,
    CL_DIVD   = 5'd11,
    CL_FRD    = 5'd12,
    CL_FCMP   = 5'd13,
    CL_FMOV   = 5'd14,
    CL_FARITH = 5'd15,
    CL_FDIV   = 5'd16,
    CL_FWR    = 5'd17,
    CL_BMOVE  = 5'd18
  } op_class_e;

  // R2 unit codes
  typedef enum logic [UNIT_W-1:0] {
    U_MOV   = 4'd0,
    U_ALU1  = 4'd1,
    U_ALU2  = 4'd2,
    U_BRU   = 4'd3,
    U_MWR   = 4'd4,
    U_MRD   = 4'd5,
    U_XPORT = 4'd6,
    U_XENG  = 4'd7,
    U_FCMP  = 4'd8,
    U_FPU1  = 4'd9,
    U_FPU2  = 4'd10,
    U_FPU3  = 4'd11,
    U_FPU4  = 4'd12,
    U_NONE  = 4'd15
  } unit_e;

  typedef logic [NUM_UNITS-1:0] umask_t;

  // Resource needs of one slot, after class decode
  typedef struct packed {
    umask_t fix;    // units that are fixed by the class
    unit_e  steer;  // unit reported when granted (ALU resolved later)
    logic   alu;    // needs one of the two ALUs
    logic   bm;     // block move: needs both issue slots
  } slot_need_t;

  function automatic umask_t ubit(input unit_e u);
    return umask_t'(1) << u;
  endfunction

endpackage

// File: rtl/hzc_class_decode.sv
module hzc_class_decode
  import hzc_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int SHD_HOLD  = 2,
  parameter int MUL_HOLD  = 3,
  parameter int DIV_HOLD  = 34,
  parameter int DIVD_HOLD = 66
) (
  input  logic [CLS_W-1:0] cls_i,
  output slot_need_t       need_o,
  output logic [CNT_W-1:0] eng_val_o   // engine counter load value (hold - 1)
);

  always_comb begin
    need_o.fix   = '0;
    need_o.steer = U_NONE;
    need_o.alu   = 1'b0;
    need_o.bm    = 1'b0;
    eng_val_o    = '0;
    case (op_class_e'(cls_i))
      // R5 single-cycle units
      CL_IMM:    begin need_o.fix = ubit(U_MOV);   need_o.steer = U_MOV;   end
      CL_BR:     begin need_o.fix = ubit(U_BRU);   need_o.steer = U_BRU;   end
      CL_MWR:    begin need_o.fix = ubit(U_MWR);   need_o.steer = U_MWR;   end
      CL_MRD:    begin need_o.fix = ubit(U_MRD);   need_o.steer = U_MRD;   end
      CL_XWR,
      CL_FRD:    begin need_o.fix = ubit(U_XPORT); need_o.steer = U_XPORT; end
      CL_FCMP:   begin need_o.fix = ubit(U_FCMP);  need_o.steer = U_FCMP;  end
      CL_FMOV:   begin need_o.fix = ubit(U_FPU1);  need_o.steer = U_FPU1;  end
      CL_FARITH: begin need_o.fix = ubit(U_FPU2);  need_o.steer = U_FPU2;  end
      CL_FWR:    begin need_o.fix = ubit(U_FPU4);  need_o.steer = U_FPU4;  end
      // R7 long FP op
      CL_FDIV:   begin need_o.fix = ubit(U_FPU3);  need_o.steer = U_FPU3;  end
      // R4 either ALU
      CL_ALU:    need_o.alu = 1'b1;
      // R6 engine operations: port plus engine
      CL_XRD: begin
        need_o.fix = ubit(U_XPORT) | ubit(U_XENG);
        need_o.steer = U_XENG;
        eng_val_o = '0;
      end
      CL_SHD: begin
        need_o.fix = ubit(U_XPORT) | ubit(U_XENG);
        need_o.steer = U_XENG;
        eng_val_o = CNT_W'(SHD_HOLD - 1);
      end
      CL_MUL: begin
        need_o.fix = ubit(U_XPORT) | ubit(U_XENG);
        need_o.steer = U_XENG;
        eng_val_o = CNT_W'(MUL_HOLD - 1);
      end
      CL_DIV: begin
        need_o.fix = ubit(U_XPORT) | ubit(U_XENG);
        need_o.steer = U_XENG;
        eng_val_o = CNT_W'(DIV_HOLD - 1);
      end
      CL_DIVD: begin
        need_o.fix = ubit(U_XPORT) | ubit(U_XENG);
        need_o.steer = U_XENG;
        eng_val_o = CNT_W'(DIVD_HOLD - 1);
      end
      // R8 block move
      CL_BMOVE: need_o.bm = 1'b1;
      // R9 no-operation and unused codes need nothing
      default: ;
    endcase
  end

endmodule

// File: rtl/hzc_unit_timer.sv
module hzc_unit_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/hzc_slot_arbiter.sv
module hzc_slot_arbiter
  import hzc_pkg::*;
(
  input  logic [1:0] valid_i,
  input  logic       lock_i,
  input  umask_t     busy_i,
  input  slot_need_t need0_i,
  input  slot_need_t need1_i,
  output logic       grant0_o,
  output logic       grant1_o,
  output umask_t     use0_o,
  output umask_t     use1_o,
  output unit_e      unit0_o,
  output unit_e      unit1_o,
  output logic       bm_start_o
);

  // Fit one slot into the free units; R4 prefers ALU 1
  function automatic void place(input slot_need_t n, input umask_t free,
                                output logic fits, output umask_t need_m,
                                output unit_e steer);
    need_m = n.fix;
    steer  = n.steer;
    if (n.alu) begin
      if (free[U_ALU1]) begin
        need_m = need_m | ubit(U_ALU1);
        steer  = U_ALU1;
      end else begin
        need_m = need_m | ubit(U_ALU2);
        steer  = U_ALU2;
      end
    end
    fits = ((need_m & ~free) == '0);
  endfunction

  umask_t free0, free1, m0, m1;
  logic   fit0, fit1;
  unit_e  st0, st1;

  always_comb begin
    free0 = ~busy_i;
    place(need0_i, free0, fit0, m0, st0);
    grant0_o = valid_i[0] & ~lock_i & fit0;
    use0_o   = grant0_o ? m0 : '0;
    unit0_o  = grant0_o ? st0 : U_NONE;

    // R3: slot 1 sees what slot 0 left; R8: no slot 1 beside a block move
    free1 = free0 & ~use0_o;
    place(need1_i, free1, fit1, m1, st1);
    grant1_o = grant0_o & valid_i[1] & ~need0_i.bm & ~need1_i.bm & fit1;
    use1_o   = grant1_o ? m1 : '0;
    unit1_o  = grant1_o ? st1 : U_NONE;

    bm_start_o = grant0_o & need0_i.bm;
  end

endmodule

// File: rtl/hzc_dual_issue_check.sv
module hzc_dual_issue_check
  import hzc_pkg::*;
#(
  parameter int SHD_HOLD   = 2,
  parameter int MUL_HOLD   = 3,
  parameter int DIV_HOLD   = 34,
  parameter int DIVD_HOLD  = 66,
  parameter int FDIV_HOLD  = 15,
  parameter int BMOVE_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] valid_i,
  input  logic [4:0] cls0_i,
  input  logic [4:0] cls1_i,
  output logic [1:0] grant_o,
  output logic [3:0] unit0_o,
  output logic [3:0] unit1_o
);

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_HOLD = max_of(max_of(max_of(SHD_HOLD, MUL_HOLD), max_of(DIV_HOLD, DIVD_HOLD)),
                                   max_of(FDIV_HOLD, BMOVE_HOLD));
  localparam int CNT_W = (MAX_HOLD > 2) ? $clog2(MAX_HOLD) : 1;

  logic [CLS_W-1:0] cls_in [2];
  slot_need_t       need   [2];
  logic [CNT_W-1:0] eng_val[2];

  assign cls_in[0] = cls0_i;
  assign cls_in[1] = cls1_i;

  for (genvar s = 0; s < 2; s++) begin : g_dec
    hzc_class_decode #(
      .CNT_W(CNT_W), .SHD_HOLD(SHD_HOLD), .MUL_HOLD(MUL_HOLD),
      .DIV_HOLD(DIV_HOLD), .DIVD_HOLD(DIVD_HOLD)
    ) u_dec (
      .cls_i    (cls_in[s]),
      .need_o   (need[s]),
      .eng_val_o(eng_val[s])
    );
  end

  umask_t busy, use0, use1;
  logic   lock, grant0, grant1, bm_start;
  unit_e  unit0, unit1;

  hzc_slot_arbiter u_arb (
    .valid_i   (valid_i),
    .lock_i    (lock),
    .busy_i    (busy),
    .need0_i   (need[0]),
    .need1_i   (need[1]),
    .grant0_o  (grant0),
    .grant1_o  (grant1),
    .use0_o    (use0),
    .use1_o    (use1),
    .unit0_o   (unit0),
    .unit1_o   (unit1),
    .bm_start_o(bm_start)
  );

  // One busy counter per unit; R6 engine and R7 FP divide load longer holds
  logic [CNT_W-1:0] ld_val [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    if (u == int'(U_XENG)) begin : g_eng
      assign ld_val[u] = use0[u] ? eng_val[0] : eng_val[1];
    end else if (u == int'(U_FPU3)) begin : g_fdiv
      assign ld_val[u] = CNT_W'(FDIV_HOLD - 1);
    end else begin : g_single
      assign ld_val[u] = '0;
    end
    hzc_unit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .load_i(use0[u] | use1[u]),
      .val_i (ld_val[u]),
      .busy_o(busy[u])
    );
  end

  // R8 block-move issue lock
  hzc_unit_timer #(.CNT_W(CNT_W)) u_lock (
    .clk   (clk),
    .rst   (rst),
    .load_i(bm_start),
    .val_i (CNT_W'(BMOVE_HOLD - 1)),
    .busy_o(lock)
  );

  // R2 registered outputs, R1 reset values
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      unit0_o <= U_NONE;
      unit1_o <= U_NONE;
    end else begin
      grant_o <= {grant1, grant0};
      unit0_o <= unit0;
      unit1_o <= unit1;
    end
  end

endmodule

// File: rtl/hzc_issue_checker.sv
module hzc_issue_checker
  import hzc_pkg::*;
#(
  parameter int BMOVE_HOLD = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [4:0] cls0_i,
  input logic [4:0] cls1_i,
  input logic [1:0] grant_o,
  input logic [3:0] unit0_o,
  input logic [3:0] unit1_o
);

  localparam int WIN_W = $clog2(BMOVE_HOLD + 1);

  logic [4:0]       cls0_q, cls1_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk) begin
    cls0_q <= cls0_i;
    cls1_q <= cls1_i;
    if (rst) begin
      win_q <= '0;
    end else if (grant_o[0] && cls0_q == CL_BMOVE) begin
      win_q <= WIN_W'(BMOVE_HOLD - 1);
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (grant_o == 2'b00 && unit0_o == U_NONE && unit1_o == U_NONE));

  p_idle_unit_r2: assert property (@(posedge clk) disable iff (rst)
    (!grant_o[0] |-> unit0_o == U_NONE) and (!grant_o[1] |-> unit1_o == U_NONE));

  p_slot_order_r3: assert property (@(posedge clk) disable iff (rst)
    grant_o[1] |-> grant_o[0]);

  p_alu_first_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_o[0] && cls0_q == CL_ALU) |-> unit0_o == U_ALU1);

  p_distinct_units_r5: assert property (@(posedge clk) disable iff (rst)
    (grant_o == 2'b11 && unit0_o != U_NONE) |-> unit0_o != unit1_o);

  p_lock_window_r8: assert property (@(posedge clk) disable iff (rst)
    (win_q != '0) |-> grant_o == 2'b00);

  p_bm_slot1_r8: assert property (@(posedge clk) disable iff (rst)
    grant_o[1] |-> cls1_q != CL_BMOVE);

endmodule

bind hzc_dual_issue_check hzc_issue_checker #(.BMOVE_HOLD(BMOVE_HOLD)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cls0_i (cls0_i),
  .cls1_i (cls1_i),
  .grant_o(grant_o),
  .unit0_o(unit0_o),
  .unit1_o(unit1_o)
);

// File: tb/hzc_dual_issue_check_test.sv
module hzc_dual_issue_check_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] valid = 2'b00;
  logic [4:0] cls0 = '0, cls1 = '0;
  logic [1:0] grant;
  logic [3:0] unit0, unit1;

  hzc_dual_issue_check uut (
    .clk(clk), .rst(rst), .valid_i(valid), .cls0_i(cls0), .cls1_i(cls1),
    .grant_o(grant), .unit0_o(unit0), .unit1_o(unit1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    errors = 0, checks = 0;
  int    busy [13];
  int    lock = 0;
  int    e_g0 = 0, e_g1 = 0, e_u0 = 15, e_u1 = 15;
  string e_tag = "R1 reset";

  // Units and hold lengths per class, from the requirement text
  task automatic needs(input int k, output int ua, output int ha, output int ub);
    ha = 1; ub = -1;
    case (k)
      1: ua = 0;  3: ua = 3;  4: ua = 4;  5: ua = 5;
      6: ua = 6;  12: ua = 6; 13: ua = 8; 14: ua = 9;
      15: ua = 10; 17: ua = 12;
      16: begin ua = 11; ha = 15; end
      7:  begin ua = 7; ha = 1;  ub = 6; end
      8:  begin ua = 7; ha = 2;  ub = 6; end
      9:  begin ua = 7; ha = 3;  ub = 6; end
      10: begin ua = 7; ha = 34; ub = 6; end
      11: begin ua = 7; ha = 66; ub = 6; end
      default: ua = -1;   // no-operation, ALU (picked later), block move
    endcase
  endtask

  task automatic model(input bit r, input bit v0, input int k0, input bit v1, input int k1);
    int  ld [13];
    bit  tk [13];
    int  ua, ha, ub;
    bit  bm0;
    e_g0 = 0; e_g1 = 0; e_u0 = 15; e_u1 = 15; bm0 = 0;
    if (r) begin
      foreach (busy[i]) busy[i] = 0;
      lock = 0;
      return;
    end
    foreach (ld[i]) begin ld[i] = -1; tk[i] = 0; end
    if (v0 && lock == 0) begin
      needs(k0, ua, ha, ub);
      if (k0 == 2) ua = (busy[1] == 0) ? 1 : 2;
      if ((ua < 0 || busy[ua] == 0) && (ub < 0 || busy[ub] == 0)) begin
        e_g0 = 1;
        bm0  = (k0 == 18);
        if (ua >= 0) begin ld[ua] = ha - 1; tk[ua] = 1; e_u0 = ua; end
        if (ub >= 0) begin ld[ub] = 0; tk[ub] = 1; end
      end
    end
    if (e_g0 == 1 && !bm0 && v1 && k1 != 18) begin
      needs(k1, ua, ha, ub);
      if (k1 == 2) ua = (busy[1] == 0 && !tk[1]) ? 1 : 2;
      if ((ua < 0 || (busy[ua] == 0 && !tk[ua])) && (ub < 0 || (busy[ub] == 0 && !tk[ub]))) begin
        e_g1 = 1;
        if (ua >= 0) begin ld[ua] = ha - 1; e_u1 = ua; end
        if (ub >= 0) ld[ub] = 0;
      end
    end
    foreach (busy[i]) begin
      if (ld[i] >= 0) busy[i] = ld[i];
      else if (busy[i] > 0) busy[i] = busy[i] - 1;
    end
    if (bm0) lock = 15;
    else if (lock > 0) lock = lock - 1;
  endtask

  task automatic compare();
    checks++;
    if (grant !== {e_g1[0], e_g0[0]} || unit0 !== 4'(e_u0) || unit1 !== 4'(e_u1)) begin
      errors++;
      $display("FAIL %s: grant=%b unit0=%0d unit1=%0d expected grant=%b unit0=%0d unit1=%0d",
               e_tag, grant, unit0, unit1, {e_g1[0], e_g0[0]}, e_u0, e_u1);
    end
  endtask

  // One clock: judge last cycle's decision, then present new candidates
  task automatic cyc(input bit r, input bit v0, input int k0, input bit v1, input int k1,
                     input string t);
    @(negedge clk);
    compare();
    rst   = r;
    valid = {v1, v0};
    cls0  = 5'(k0);
    cls1  = 5'(k1);
    model(r, v0, k0, v1, k1);
    e_tag = t;
  endtask

  task automatic rep(input int n, input bit v0, input int k0, input bit v1, input int k1,
                     input string t);
    for (int i = 0; i < n; i++) cyc(0, v0, k0, v1, k1, t);
  endtask

  initial begin
    foreach (busy[i]) busy[i] = 0;
    rep(0, 0, 0, 0, 0, "R1");
    cyc(1, 1, 2, 1, 2, "R1 reset state");
    cyc(1, 1, 9, 0, 0, "R1 reset state");
    // R2 latency and unit codes
    cyc(0, 1, 1, 0, 0, "R2 single grant");
    cyc(0, 0, 0, 0, 0, "R2 idle");
    cyc(0, 1, 0, 1, 0, "R9 nop pair");
    // R4 ALU steering
    rep(3, 1, 2, 1, 2, "R4 alu pair");
    cyc(0, 1, 1, 1, 2, "R4 alu in slot 1 alone");
    // R3 ordering and same-cycle conflicts
    cyc(0, 0, 2, 1, 2, "R3 slot0 empty");
    cyc(0, 1, 5, 1, 5, "R3 read port conflict");
    cyc(0, 1, 3, 1, 1, "R3 branch plus move");
    cyc(0, 1, 6, 1, 12, "R3 port conflict");
    // R5 one-cycle units back to back
    rep(3, 1, 5, 1, 4, "R5 memory ports");
    rep(2, 1, 13, 1, 14, "R5 fp compare and move");
    rep(2, 1, 15, 1, 17, "R5 fp arith and write");
    rep(2, 1, 12, 1, 6, "R5 port sharing");
    // R6 engine holds
    cyc(0, 1, 9, 1, 12, "R6 mul with port");
    rep(5, 1, 9, 1, 12, "R6 mul repeat");
    rep(4, 1, 8, 1, 6, "R6 shift repeat");
    rep(3, 1, 7, 1, 12, "R6 eam read");
    cyc(0, 1, 10, 0, 0, "R6 divide");
    rep(36, 1, 12, 1, 7, "R6 port free engine busy");
    cyc(0, 1, 11, 0, 0, "R6 double divide");
    rep(70, 1, 7, 1, 12, "R6 engine release");
    // R7 FP divide
    rep(35, 1, 16, 1, 15, "R7 fp divide repeat");
    cyc(0, 1, 15, 1, 16, "R7 fp divide slot 1");
    rep(16, 1, 14, 1, 16, "R7 fp divide slot 1 wait");
    // R8 block move
    rep(3, 1, 2, 1, 18, "R8 block move in slot 1");
    cyc(0, 1, 18, 1, 2, "R8 block move start");
    rep(20, 1, 2, 1, 2, "R8 lock window");
    cyc(0, 1, 10, 0, 0, "R8 divide before block move");
    cyc(0, 1, 18, 0, 0, "R8 block move with engine busy");
    rep(20, 1, 9, 1, 12, "R8 lock then engine");
    // R1 reset in the middle of a long hold
    cyc(0, 1, 11, 0, 0, "R1 long hold");
    cyc(0, 1, 18, 0, 0, "R1 block move");
    cyc(1, 1, 9, 0, 0, "R1 reset mid hold");
    rep(3, 1, 9, 1, 16, "R1 after reset");
    // Random mix of all classes, occasional reset
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom_range(0, 199) == 0), 1'($urandom), int'($urandom_range(0, 18)),
          1'($urandom), int'($urandom_range(0, 18)), "R2 random mix");
    end
    cyc(0, 0, 0, 0, 0, "R2 drain");
    @(negedge clk);
    compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule